// File: doc/BRIEF.md
# UART Receive Buffer with Character Timeout

This block sits on the receive side of a 16550-style serial port. It sits between the deserializer and the register-read path. Each received byte is queued in a 16-entry first-in-first-out store. A received break is queued as a zero byte. The block tracks the fill level and drives the line-status flags for data-ready, overrun and break. It also raises a trigger indication when the fill level reaches a programmable threshold.

A character-timeout timer counts bit-period ticks from the baud generator. It flags data that has waited four character times without service. The frame length used for that timeout follows the line-control settings for word length, parity and stop bits.

With the buffer disabled, the block behaves as a single holding register. The register block drives a data-read strobe, a line-status-read strobe and a buffer-control write. The interrupt encoder uses the trigger and timeout outputs.

Top module: `uart_rx_buffer`

## Requirements
- R1: In buffer mode, a byte that arrives while 16 bytes are held is discarded. The held bytes and the level stay unchanged, and `overrun` is set.
- R2: The trigger threshold comes from `fifo_ctl[7:6]`: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. In buffer mode, `trig_hit` is high when `data_ready` is set and `level` is at least the threshold. In holding-register mode, `trig_hit` equals `data_ready`.
- R3: In buffer mode, the timeout is restarted by every received data byte and by a read that leaves the buffer non-empty. `timeout_pend` rises after exactly 4 × (character bits) `bit_tick` pulses following the restart, provided the buffer still holds data.
- R4: A pulse on `rd_stb` clears `timeout_pend`. In buffer mode with an empty buffer, `rd_data` is 0x00.
- R5: A read that empties the buffer clears both `data_ready` and `brk_ind`.
- R6: A pulse on `rx_break` stores a 0x00 byte and sets both `brk_ind` and `data_ready`. If `rx_valid` is high in the same cycle, the break takes priority.
- R7: Character bits = 1 + (5 + `frm_len`) + `frm_par_en` + (1 + `frm_stop2`). For example, 8 data bits with no parity and one stop bit gives 10 bits, a limit of 40 ticks. Five data bits with parity and two stop bits gives 9 bits, a limit of 36.
- R8: A buffer-control write flushes the buffer when `fifo_ctl[1]` is set, or when `fifo_ctl[0]` (buffer enable) differs from the current mode. A flush empties the buffer, clears `data_ready`, stops the timer and clears `timeout_pend`.
- R9: In holding-register mode (`fifo_ctl[0]`=0), a byte arriving while `data_ready` is set replaces the held byte and sets `overrun`. A read clears `data_ready`.
- R10: While `baud_div_zero` is high, ticks are ignored and the timeout does not advance.
- R11: `overrun` stays set until a `lsr_rd_stb` pulse. `brk_ind` is cleared by `lsr_rd_stb` or by the emptying read of R5.
- R12: Bytes leave in arrival order. `rd_data` shows the oldest byte, and `rd_stb` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Received break event |
| rd_stb | input | 1 | Data-register read strobe |
| lsr_rd_stb | input | 1 | Line-status read strobe |
| fifo_wr | input | 1 | Buffer-control write strobe |
| fifo_ctl | input | 8 | Control: [0] enable, [1] flush, [7:6] threshold |
| frm_len | input | 2 | Word length minus 5 |
| frm_par_en | input | 1 | Parity bit present |
| frm_stop2 | input | 1 | Two stop bits |
| bit_tick | input | 1 | One pulse per bit period |
| baud_div_zero | input | 1 | Baud divisor is zero, timer halted |
| rd_data | output | 8 | Oldest byte, or the holding register |
| level | output | 5 | Bytes held |
| data_ready | output | 1 | Data-ready flag |
| overrun | output | 1 | Overrun flag |
| brk_ind | output | 1 | Break flag |
| trig_hit | output | 1 | Threshold reached |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
The flags, the level and `rd_data` change on the first clock edge after the strobe that causes them. The bench drives each strobe for one cycle from a falling edge and checks at the next falling edge. `timeout_pend` is due on the edge of the limit-th tick after the restart. The bench therefore gives one tick fewer than the limit and checks that the flag is still low, then gives one more tick and checks that it is high. This brackets the exact cycle for both frame formats of R7.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;

   typedef enum logic [1:0] {TRIG_1 = 2'b00, TRIG_4 = 2'b01, TRIG_8 = 2'b10, TRIG_14 = 2'b11} trig_sel_e;

   function automatic logic [4:0] trig_bytes(input trig_sel_e sel);
      case (sel)
         TRIG_1:  return 5'd1;
         TRIG_4:  return 5'd4;
         TRIG_8:  return 5'd8;
         default: return 5'd14;
      endcase
   endfunction

   // start + (5+len) data + parity + (1+stop2) stop
   function automatic logic [3:0] char_bits(input logic [1:0] len, input logic par, input logic stop2);
      return 4'd7 + {2'b00, len} + {3'b000, par} + {3'b000, stop2};
   endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
   parameter int DEPTH = 16,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_en,
   input  logic          flush,
   input  logic          rx_valid,
   input  logic [7:0]    rx_byte,
   input  logic          rx_break,
   input  logic          rd_stb,
   input  logic          lsr_rd_stb,
   output logic [7:0]    rd_data,
   output logic [CW-1:0] level,
   output logic          data_ready,
   output logic          overrun,
   output logic          brk_ind,
   output logic          kick
);
   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [7:0]    hold_q;
   logic [CW-1:0] lvl_nxt;
   logic          brk_ev, byte_ev, in_ev, full, empty, do_push, do_pop;
   logic          ovr_set, rd_clr, dr_nxt;
   logic [7:0]    in_data;

   assign brk_ev  = rx_break & ~flush;
   assign byte_ev = rx_valid & ~rx_break & ~flush;
   assign in_ev   = brk_ev | byte_ev;
   assign in_data = brk_ev ? 8'h00 : rx_byte;
   assign full    = (level == CW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = fifo_en & in_ev & ~full;
   assign do_pop  = fifo_en & rd_stb & ~flush & ~empty;
   assign lvl_nxt = level + CW'(do_push) - CW'(do_pop);
   assign ovr_set = fifo_en ? (in_ev & full) : (byte_ev & data_ready);
   assign rd_clr  = fifo_en ? (do_pop & (lvl_nxt == '0)) : (rd_stb & ~flush);
   assign kick    = fifo_en & ~flush & (byte_ev | (do_pop & (lvl_nxt != '0)));

   always_comb begin
      if (flush)       dr_nxt = 1'b0;
      else if (in_ev)  dr_nxt = 1'b1;
      else if (rd_clr) dr_nxt = 1'b0;
      else             dr_nxt = data_ready;
   end

   always_comb begin
      if (fifo_en) rd_data = empty ? 8'h00 : mem[rd_ptr];
      else         rd_data = hold_q;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr     <= '0;
         rd_ptr     <= '0;
         level      <= '0;
         hold_q     <= 8'h00;
         data_ready <= 1'b0;
         overrun    <= 1'b0;
         brk_ind    <= 1'b0;
      end else begin
         if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
         end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            level <= lvl_nxt;
         end
         if (!fifo_en && in_ev) hold_q <= in_data;
         data_ready <= dr_nxt;
         if (ovr_set)         overrun <= 1'b1;
         else if (lsr_rd_stb) overrun <= 1'b0;
         if (brk_ev)                    brk_ind <= 1'b1;
         else if (lsr_rd_stb || rd_clr) brk_ind <= 1'b0;
      end
   end
endmodule

// File: rtl/rxb_char_timer.sv
module rxb_char_timer #(
   parameter int TMO_CHARS = 4,
   parameter int MAX_BITS  = 12,
   localparam int TW = $clog2(TMO_CHARS * MAX_BITS + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] bits,
   input  logic       bit_tick,
   input  logic       halt,
   input  logic       kick,
   input  logic       flush,
   input  logic       rd_stb,
   input  logic       has_data,
   output logic       timeout_pend
);
   logic [TW-1:0] cnt, limit;
   logic          armed, step, expire;

   assign limit  = TW'(TMO_CHARS) * TW'(bits);
   assign step   = armed & bit_tick & ~halt & ~kick & ~flush;
   assign expire = step & ((cnt + 1'b1) == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed        <= 1'b0;
         cnt          <= '0;
         timeout_pend <= 1'b0;
      end else begin
         if (flush) begin
            armed <= 1'b0;
            cnt   <= '0;
         end else if (kick) begin
            armed <= 1'b1;
            cnt   <= '0;
         end else if (expire) begin
            armed <= 1'b0;
            cnt   <= '0;
         end else if (step) begin
            cnt <= cnt + 1'b1;
         end
         if (flush || rd_stb)       timeout_pend <= 1'b0;
         else if (expire && has_data) timeout_pend <= 1'b1;
      end
   end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
   import uart_rxb_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int TMO_CHARS = 4,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [7:0]    rx_byte,
   input  logic          rx_break,
   input  logic          rd_stb,
   input  logic          lsr_rd_stb,
   input  logic          fifo_wr,
   input  logic [7:0]    fifo_ctl,
   input  logic [1:0]    frm_len,
   input  logic          frm_par_en,
   input  logic          frm_stop2,
   input  logic          bit_tick,
   input  logic          baud_div_zero,
   output logic [7:0]    rd_data,
   output logic [CW-1:0] level,
   output logic          data_ready,
   output logic          overrun,
   output logic          brk_ind,
   output logic          trig_hit,
   output logic          timeout_pend
);
   generate
      if (DEPTH < 14) begin : g_bad_depth
         $error("DEPTH must hold the largest trigger threshold (14)");
      end
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
         $error("DEPTH must be a power of two for pointer wrap");
      end
      if (TMO_CHARS < 1) begin : g_bad_tmo
         $error("TMO_CHARS must be at least 1");
      end
   endgenerate

   logic      fifo_en_q;
   trig_sel_e trig_q;
   logic      flush, kick;

   assign flush = fifo_wr & (fifo_ctl[1] | (fifo_ctl[0] ^ fifo_en_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_en_q <= 1'b0;
         trig_q    <= TRIG_1;
      end else if (fifo_wr) begin
         fifo_en_q <= fifo_ctl[0];
         trig_q    <= trig_sel_e'(fifo_ctl[7:6]);
      end
   end

   rxb_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en_q), .flush(flush),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
      .rd_stb(rd_stb), .lsr_rd_stb(lsr_rd_stb), .rd_data(rd_data),
      .level(level), .data_ready(data_ready), .overrun(overrun),
      .brk_ind(brk_ind), .kick(kick)
   );

   rxb_char_timer #(.TMO_CHARS(TMO_CHARS)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .bits(char_bits(frm_len, frm_par_en, frm_stop2)),
      .bit_tick(bit_tick), .halt(baud_div_zero), .kick(kick),
      .flush(flush), .rd_stb(rd_stb), .has_data(level != '0),
      .timeout_pend(timeout_pend)
   );

   assign trig_hit = data_ready & (~fifo_en_q | (level >= CW'(trig_bytes(trig_q))));
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_valid,
   input logic          rx_break,
   input logic          rd_stb,
   input logic          fifo_wr,
   input logic [7:0]    fifo_ctl,
   input logic          baud_div_zero,
   input logic          fifo_en,
   input logic [CW-1:0] level,
   input logic [7:0]    rd_data,
   input logic          data_ready,
   input logic          overrun,
   input logic          brk_ind,
   input logic          timeout_pend
);
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH)); // R1
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && level == CW'(DEPTH) && rx_valid && !rx_break && !rd_stb && !fifo_wr
      |=> level == CW'(DEPTH) && overrun); // R1
   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && level == '0 |-> rd_data == 8'h00); // R4
   AST_READ_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !timeout_pend); // R4
   AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_break && !fifo_wr |=> brk_ind && data_ready); // R6
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr && fifo_ctl[1] |=> level == '0 && !data_ready && !timeout_pend); // R8
   AST_HALT_NO_TMO: assert property (@(posedge clk) disable iff (!rst_n)
      baud_div_zero && !timeout_pend |=> !timeout_pend); // R10
endmodule

bind uart_rx_buffer rxb_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_break(rx_break),
   .rd_stb(rd_stb), .fifo_wr(fifo_wr), .fifo_ctl(fifo_ctl),
   .baud_div_zero(baud_div_zero), .fifo_en(fifo_en_q), .level(level),
   .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun),
   .brk_ind(brk_ind), .timeout_pend(timeout_pend)
);

// File: tb/sim_uart_rx_buffer.sv
module sim_uart_rx_buffer;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 0, rx_break = 0, rd_stb = 0, lsr_rd_stb = 0, fifo_wr = 0;
   logic [7:0] rx_byte = 0, fifo_ctl = 0;
   logic [1:0] frm_len = 2'd3;
   logic       frm_par_en = 0, frm_stop2 = 0, bit_tick = 0, baud_div_zero = 0;
   logic [7:0] rd_data;
   logic [4:0] level;
   logic       data_ready, overrun, brk_ind, trig_hit, timeout_pend;
   int checks = 0, errors = 0;
   logic [7:0] v;

   // [7:6] threshold select, [5:1] bytes pushed, [0] expected trig_hit
   localparam logic [7:0] TRIG_VEC [8] = '{
      {2'b00, 5'd1,  1'b1}, {2'b01, 5'd3,  1'b0}, {2'b01, 5'd4,  1'b1},
      {2'b10, 5'd7,  1'b0}, {2'b10, 5'd8,  1'b1}, {2'b11, 5'd13, 1'b0},
      {2'b11, 5'd14, 1'b1}, {2'b00, 5'd0,  1'b0}};

   always #(CLK_P/2) clk = ~clk;

   uart_rx_buffer u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_break(rx_break), .rd_stb(rd_stb), .lsr_rd_stb(lsr_rd_stb),
      .fifo_wr(fifo_wr), .fifo_ctl(fifo_ctl), .frm_len(frm_len),
      .frm_par_en(frm_par_en), .frm_stop2(frm_stop2), .bit_tick(bit_tick),
      .baud_div_zero(baud_div_zero), .rd_data(rd_data), .level(level),
      .data_ready(data_ready), .overrun(overrun), .brk_ind(brk_ind),
      .trig_hit(trig_hit), .timeout_pend(timeout_pend)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      rx_valid = 1; rx_byte = b;
      @(negedge clk);
      rx_valid = 0;
   endtask

   task automatic brk();
      rx_break = 1;
      @(negedge clk);
      rx_break = 0;
   endtask

   task automatic rd(output logic [7:0] b);
      b = rd_data; rd_stb = 1;
      @(negedge clk);
      rd_stb = 0;
   endtask

   task automatic lsr();
      lsr_rd_stb = 1;
      @(negedge clk);
      lsr_rd_stb = 0;
   endtask

   task automatic ctl(input logic [7:0] c);
      fifo_wr = 1; fifo_ctl = c;
      @(negedge clk);
      fifo_wr = 0;
   endtask

   task automatic ticks(input int n);
      bit_tick = 1;
      repeat (n) @(negedge clk);
      bit_tick = 0;
   endtask

   initial begin
      #(CLK_P * 20000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("reset data_ready", data_ready, 0);
      chk("reset level", level, 0);
      chk("reset flags", {overrun, brk_ind, trig_hit, timeout_pend}, 0);
      chk("reset rd_data", rd_data, 0);

      // R2 threshold table
      for (int i = 0; i < 8; i++) begin
         ctl({TRIG_VEC[i][7:6], 6'b000011});
         for (int k = 0; k < int'(TRIG_VEC[i][5:1]); k++) push(8'(k));
         chk($sformatf("R2 level vec%0d", i), level, 5'(TRIG_VEC[i][5:1]));
         chk($sformatf("R2 trig_hit vec%0d", i), trig_hit, TRIG_VEC[i][0]);
      end

      // R12 order, R5 emptying read, R4 empty read
      ctl(8'h03);
      push(8'hA1); push(8'hB2); push(8'hC3);
      rd(v); chk("R12 first", v, 8'hA1);
      rd(v); chk("R12 second", v, 8'hB2);
      rd(v); chk("R12 third", v, 8'hC3);
      chk("R5 dr cleared", data_ready, 0);
      chk("R4 empty rd_data", rd_data, 8'h00);

      // R1 overflow, R11 sticky overrun
      for (int k = 0; k < 16; k++) push(8'(8'h10 + k));
      push(8'hEE);
      chk("R1 level full", level, 16);
      chk("R1 overrun", overrun, 1);
      rd(v); chk("R1 oldest kept", v, 8'h10);
      for (int k = 1; k < 15; k++) rd(v);
      rd(v); chk("R1 newest kept", v, 8'h1F);
      chk("R11 overrun sticky", overrun, 1);
      lsr();
      chk("R11 overrun cleared", overrun, 0);

      // R6 break, R5 break cleared on emptying read
      push(8'h55); brk();
      chk("R6 level", level, 2);
      chk("R6 flags", {brk_ind, data_ready}, 2'b11);
      rd(v); chk("R6 data first", v, 8'h55);
      chk("R5 brk kept", brk_ind, 1);
      rd(v); chk("R6 null byte", v, 8'h00);
      chk("R5 brk+dr cleared", {brk_ind, data_ready}, 2'b00);
      brk(); lsr();
      chk("R11 brk cleared by lsr", {brk_ind, data_ready}, 2'b01);
      rd(v);

      // R3/R7 timeout for 8N1: limit 40
      push(8'h01);
      ticks(39); chk("R3 no tmo at 39", timeout_pend, 0);
      ticks(1);  chk("R7 tmo at 40", timeout_pend, 1);
      rd(v); chk("R4 read clears tmo", timeout_pend, 0);
      ticks(60); chk("R3 empty no tmo", timeout_pend, 0);

      // R3 restart by non-emptying read
      push(8'h02); push(8'h03);
      ticks(30); rd(v);
      ticks(39); chk("R3 restarted by read", timeout_pend, 0);
      ticks(1);  chk("R3 tmo after read restart", timeout_pend, 1);
      rd(v);

      // R7 five bits, parity, two stop: limit 36
      frm_len = 2'd0; frm_par_en = 1; frm_stop2 = 1;
      push(8'h04);
      ticks(35); chk("R7 no tmo at 35", timeout_pend, 0);
      ticks(1);  chk("R7 tmo at 36", timeout_pend, 1);
      rd(v);

      // R10 halted timer
      push(8'h05);
      baud_div_zero = 1;
      ticks(100); chk("R10 halted", timeout_pend, 0);
      baud_div_zero = 0;
      ticks(35); chk("R10 resumes count", timeout_pend, 0);
      ticks(1);  chk("R10 tmo after resume", timeout_pend, 1);

      // R8 flush
      ctl(8'h03);
      chk("R8 flush state", {level, data_ready, timeout_pend}, 0);
      push(8'h06);
      ctl(8'h03);
      ticks(60); chk("R8 timer stopped", timeout_pend, 0);
      push(8'h07); push(8'h08);
      ctl(8'h00);
      chk("R8 mode change flush", {level, data_ready}, 0);

      // R9 holding-register mode
      push(8'h41);
      chk("R9 dr", data_ready, 1);
      chk("R9 data", rd_data, 8'h41);
      chk("R2 trig in hold mode", trig_hit, 1);
      push(8'h42);
      chk("R9 overwrite", rd_data, 8'h42);
      chk("R9 overrun", overrun, 1);
      rd(v);
      chk("R9 read clears dr", data_ready, 0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule